// File: doc/BRIEF.md
# Angle Output Hold Latch

This block stands between a free-running angle up/down counter and a host that reads the angle over an asynchronous bus. A 16-bit holding register normally copies the counter on every clock. The host drives an active-low hold request to freeze that register while it reads. The counter side raises a busy pulse around each change of its value. The block arbitrates between busy and the hold request so that the host never reads a value that is only partly updated.

Busy always freezes the register at once. A hold request that arrives while busy is high does not take effect until busy has fallen. On the first idle edge the register takes the settled value, and it then stays frozen. A hold request made before busy keeps the register frozen through the busy pulse and afterwards. The block also gives the counter a one-cycle step strobe a fixed number of cycles after each rising edge of busy. This delay means the counter only moves after the freeze has taken effect. Hold never suppresses this strobe.

The value is read through two byte lanes, each with its own active-low enable. A lane floats when its enable is high. The lane enables and the hold request are asynchronous and pass through synchronisers, and lane turn-on and turn-off take parameterised numbers of cycles. A resolution select chooses full 16-bit output or 14-bit output, where the two lowest bits read zero.

Top module: `angle_hold_latch`

## Requirements
- R1: With busy low and no hold in force, every rising clock edge copies `cnt_angle` into the holding register. The lanes show the copied value in the following cycle.
- R2: On every edge at which `cnt_busy` is high, the holding register keeps its value, whatever the state of `hold_n`.
- R3: A hold request that becomes active while busy is high does not freeze the register by itself. On the first edge with busy low, the register loads `cnt_angle` and then stays frozen while the request lasts.
- R4: When a hold is already in force and busy pulses, the register stays frozen during busy and after busy falls, for as long as `hold_n` stays low.
- R5: When `hold_n` falls, the register takes its last load at rising edge number SYNC_STAGES+1, counted from the first edge after the fall. It holds that value from then on.
- R6: `cnt_step` is high for exactly one cycle. It becomes visible after rising edge number STEP_DLY, counting the first edge that samples `cnt_busy` high after it was low as edge 1.
- R7: `cnt_step` still fires as in R6 while a hold is in force.
- R8: `hi_lane` carries bits 15..8 of the holding register while enabled and is high-impedance otherwise. After `hi_oe_n` falls, the lane turns on at rising edge SYNC_STAGES+OE_ON_DLY. After `hi_oe_n` rises, the lane turns off at rising edge SYNC_STAGES+OE_OFF_DLY.
- R9: `lo_lane` follows the same timing rules as R8, using `lo_oe_n`. The two lanes work independently. With `res14` low, `lo_lane` carries bits 7..0.
- R10: With `res14` high, `lo_lane` carries bits 7..2 of the holding register in positions 7..2 and drives zero in positions 1..0.
- R11: After `hold_n` rises, the register resumes copying at rising edge SYNC_STAGES+2.
- R12: During reset, both lanes are high-impedance, `cnt_step` is low, and the holding register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_angle | input | 16 | Angle value from the counter |
| cnt_busy | input | 1 | Counter busy pulse, synchronous to clk |
| hold_n | input | 1 | Host hold request, active low, asynchronous |
| res14 | input | 1 | 1 selects 14-bit output, 0 selects 16-bit output |
| hi_oe_n | input | 1 | Upper-byte lane enable, active low, asynchronous |
| lo_oe_n | input | 1 | Lower-byte lane enable, active low, asynchronous |
| cnt_step | output | 1 | One-cycle strobe that permits the counter to change |
| hi_lane | output | 8 | Upper byte of the held angle, tri-state |
| lo_lane | output | 8 | Lower byte of the held angle, tri-state |

## Verification
The copy path is swept over 256 spread-out angles in 16-bit mode and 64 angles in 14-bit mode. A swapped byte, a dropped bit or an unmasked low pair each shows up as a mismatch. The arbitration is tried in three orders: busy alone, hold raised during busy, and hold raised before busy. Only a correct design gives the expected result in all three: a frozen value in the first, the post-busy value in the second, and the pre-busy value in the third. Hold fall, hold rise, lane turn-on and lane turn-off are each checked on the cycle before and the cycle of the expected change. This catches an extra or a missing pipeline stage, and the step strobe is timed the same way inside each busy pulse.

// File: rtl/angle_latch_pkg.sv
package angle_latch_pkg;
    localparam int LANE_W  = 8;
    localparam int ANGLE_W = 2 * LANE_W;

    typedef struct packed {
        logic [ANGLE_W-1:0] held;
        logic               inh_lock;
    } core_t;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/lane_gate.sv
module lane_gate #(
    parameter int ON_DLY  = 2,
    parameter int OFF_DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic on
);
    localparam int MAXD = (ON_DLY > OFF_DLY) ? ON_DLY : OFF_DLY;
    localparam int CW   = (MAXD > 1) ? $clog2(MAXD) : 1;
    localparam logic [CW-1:0] ON_LIM  = CW'(ON_DLY - 1);
    localparam logic [CW-1:0] OFF_LIM = CW'(OFF_DLY - 1);

    typedef struct packed {
        logic          on;
        logic [CW-1:0] cnt;
    } gate_t;

    gate_t gate_d, gate_q;
    logic [CW-1:0] lim;

    always_comb begin
        gate_d = gate_q;
        lim    = gate_q.on ? OFF_LIM : ON_LIM;
        if (req != gate_q.on) begin
            if (gate_q.cnt == lim) begin
                gate_d.on  = req;
                gate_d.cnt = '0;
            end else begin
                gate_d.cnt = gate_q.cnt + 1'b1;
            end
        end else begin
            gate_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

    assign on = gate_q.on;
endmodule

// File: rtl/busy_delay.sv
module busy_delay #(
    parameter int DLY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic step
);
    typedef struct packed {
        logic           busy_prev;
        logic [DLY-1:0] pipe;
    } dly_t;

    dly_t dly_d, dly_q;
    logic rise;

    always_comb begin
        rise            = busy && !dly_q.busy_prev;
        dly_d.busy_prev = busy;
        dly_d.pipe      = {dly_q.pipe, rise} >> 0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_q <= '0;
        else        dly_q <= dly_d;
    end

    assign step = dly_q.pipe[DLY-1];
endmodule

// File: rtl/angle_hold_latch.sv
module angle_hold_latch
    import angle_latch_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int OE_ON_DLY   = 2,
    parameter int OE_OFF_DLY  = 3,
    parameter int STEP_DLY    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ANGLE_W-1:0] cnt_angle,
    input  logic              cnt_busy,
    input  logic              hold_n,
    input  logic              res14,
    input  logic              hi_oe_n,
    input  logic              lo_oe_n,
    output logic              cnt_step,
    output wire  [LANE_W-1:0] hi_lane,
    output wire  [LANE_W-1:0] lo_lane
);
    localparam int NLANE = 2;
    localparam logic [LANE_W-1:0] MASK14 = {{(LANE_W-2){1'b1}}, 2'b00};

    logic [2:0]       async_in, sync_out;
    logic             inh_act;
    logic [NLANE-1:0] lane_req, lane_on;
    logic [LANE_W-1:0] lane_data [NLANE];
    logic [ANGLE_W-1:0] held_now;

    core_t core_d, core_q;

    assign async_in = {hold_n, hi_oe_n, lo_oe_n};

    bit_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (async_in),
        .dout (sync_out)
    );

    assign inh_act     = !sync_out[2];
    assign lane_req[1] = !sync_out[1];
    assign lane_req[0] = !sync_out[0];

    // Lock arbitration: busy blocks loads; the hold lock is only taken on an idle edge
    always_comb begin
        core_d          = core_q;
        core_d.inh_lock = inh_act && (core_q.inh_lock || !cnt_busy);
        if (!cnt_busy && !core_q.inh_lock) begin
            core_d.held = cnt_angle;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign held_now = core_q.held;

    busy_delay #(.DLY(STEP_DLY)) u_step (
        .clk  (clk),
        .rst_n(rst_n),
        .busy (cnt_busy),
        .step (cnt_step)
    );

    assign lane_data[1] = core_q.held[ANGLE_W-1:LANE_W];
    assign lane_data[0] = res14 ? (core_q.held[LANE_W-1:0] & MASK14)
                                :  core_q.held[LANE_W-1:0];

    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_lane
            lane_gate #(.ON_DLY(OE_ON_DLY), .OFF_DLY(OE_OFF_DLY)) u_gate (
                .clk  (clk),
                .rst_n(rst_n),
                .req  (lane_req[g]),
                .on   (lane_on[g])
            );
        end
    endgenerate

    assign hi_lane = lane_on[1] ? lane_data[1] : 'z;
    assign lo_lane = lane_on[0] ? lane_data[0] : 'z;
endmodule

// File: rtl/angle_hold_latch_chk.sv
module angle_hold_latch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cnt_angle,
    input logic        cnt_busy,
    input logic        cnt_step,
    input logic [15:0] held,
    input logic        inh_lock,
    input logic        hi_on,
    input logic        hi_req
);
    a_r1_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_busy && !inh_lock) |=> (held == $past(cnt_angle)));

    a_r2_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_busy |=> $stable(held));

    a_r3_defer_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_busy && !inh_lock) |=> !inh_lock);

    a_r4_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        inh_lock |=> $stable(held));

    a_r6_step_single: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_step |=> !cnt_step);

    a_r8_turn_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_on) |-> $past(hi_req));
endmodule

bind angle_hold_latch angle_hold_latch_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_angle(cnt_angle),
    .cnt_busy (cnt_busy),
    .cnt_step (cnt_step),
    .held     (held_now),
    .inh_lock (core_q.inh_lock),
    .hi_on    (lane_on[1]),
    .hi_req   (lane_req[1])
);

// File: tb/angle_hold_latch_tb.sv
module angle_hold_latch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_angle = '0;
    logic        cnt_busy = 1'b0;
    logic        hold_n = 1'b1;
    logic        res14 = 1'b0;
    logic        hi_oe_n = 1'b1;
    logic        lo_oe_n = 1'b1;
    logic        cnt_step;
    wire  [7:0]  hi_w;
    wire  [7:0]  lo_w;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pullup pu_hi[7:0] (hi_w);
    pullup pu_lo[7:0] (lo_w);

    angle_hold_latch u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_angle(cnt_angle),
        .cnt_busy (cnt_busy),
        .hold_n   (hold_n),
        .res14    (res14),
        .hi_oe_n  (hi_oe_n),
        .lo_oe_n  (lo_oe_n),
        .cnt_step (cnt_step),
        .hi_lane  (hi_w),
        .lo_lane  (lo_w)
    );

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_word(input string tag, input logic [15:0] exp);
        chk(tag, {hi_w, lo_w}, exp);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        tick(3);
        // R12: lanes float (pulled up), no step during reset
        chk("R12 lanes idle", {hi_w, lo_w}, 16'hFFFF);
        chk("R12 step low", {15'd0, cnt_step}, 16'd0);
        rst_n   = 1'b1;
        hi_oe_n = 1'b0;
        lo_oe_n = 1'b0;
        tick(6);
        chk_word("R12 held zero", 16'h0000);

        // R1: transparent sweep, 16-bit mode
        for (int a = 0; a < 256; a++) begin
            v = 16'(a * 613 + a * 256) ^ 16'h1357;
            cnt_angle = v;
            tick(1);
            chk_word("R1 follow", v);
        end

        // R10: 14-bit mode sweep
        res14 = 1'b1;
        for (int a = 0; a < 64; a++) begin
            v = 16'(a * 1031) ^ 16'h2A5F;
            cnt_angle = v;
            tick(1);
            chk_word("R10 res14", {v[15:2], 2'b00});
        end
        res14 = 1'b0;

        // R2 + R6: busy freezes, step after STEP_DLY edges
        cnt_angle = 16'hA1B2;
        tick(1);
        cnt_busy = 1'b1;
        for (int k = 1; k <= 6; k++) begin
            cnt_angle = 16'h0100 + 16'(k);
            tick(1);
            chk_word("R2 busy freeze", 16'hA1B2);
            chk("R6 step timing", {15'd0, cnt_step}, (k == 3) ? 16'd1 : 16'd0);
        end
        cnt_busy  = 1'b0;
        cnt_angle = 16'hC3D4;
        tick(1);
        chk_word("R1 after busy", 16'hC3D4);

        // R3: hold requested during busy
        cnt_busy  = 1'b1;
        cnt_angle = 16'h1111;
        tick(1);
        hold_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            cnt_angle = 16'h2220 + 16'(k);
            tick(1);
            chk_word("R3 busy still holds", 16'hC3D4);
        end
        cnt_busy  = 1'b0;
        cnt_angle = 16'h5E6F;
        tick(1);
        chk_word("R3 post-busy load", 16'h5E6F);
        for (int k = 0; k < 3; k++) begin
            cnt_angle = 16'h7700 + 16'(k);
            tick(1);
            chk_word("R3 then frozen", 16'h5E6F);
        end

        // R11: release timing
        hold_n    = 1'b1;
        cnt_angle = 16'h6A7B;
        tick(3);
        chk_word("R11 before resume", 16'h5E6F);
        tick(1);
        chk_word("R11 resume", 16'h6A7B);

        // R4 + R7: hold before busy
        hold_n    = 1'b0;
        cnt_angle = 16'h4C4D;
        tick(4);
        chk_word("R4 locked", 16'h4C4D);
        cnt_busy = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            cnt_angle = 16'h9000 + 16'(k);
            tick(1);
            chk_word("R4 busy under hold", 16'h4C4D);
            chk("R7 step under hold", {15'd0, cnt_step}, (k == 3) ? 16'd1 : 16'd0);
        end
        cnt_busy  = 1'b0;
        cnt_angle = 16'hE0E1;
        for (int k = 0; k < 3; k++) begin
            tick(1);
            chk_word("R4 after busy", 16'h4C4D);
        end
        hold_n = 1'b1;
        tick(4);
        chk_word("R4 released", 16'hE0E1);

        // R5: capture edge on hold fall
        hold_n    = 1'b0;
        cnt_angle = 16'h0A00;
        tick(1);
        cnt_angle = 16'h0A01;
        tick(1);
        cnt_angle = 16'h0A02;
        tick(1);
        cnt_angle = 16'h0A03;
        chk_word("R5 last load", 16'h0A02);
        tick(1);
        cnt_angle = 16'h0A04;
        tick(1);
        chk_word("R5 stable", 16'h0A02);
        hold_n = 1'b1;
        cnt_angle = 16'h3C5A;
        tick(5);
        chk_word("R1 settle", 16'h3C5A);

        // R8: upper lane enable/disable timing
        hi_oe_n = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            tick(1);
            chk("R8 hi off timing", {8'h00, hi_w}, (k >= 5) ? 16'h00FF : 16'h003C);
            chk("R9 lo unaffected", {8'h00, lo_w}, 16'h005A);
        end
        hi_oe_n = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            tick(1);
            chk("R8 hi on timing", {8'h00, hi_w}, (k >= 4) ? 16'h003C : 16'h00FF);
        end

        // R9: lower lane enable/disable timing
        lo_oe_n = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            tick(1);
            chk("R9 lo off timing", {8'h00, lo_w}, (k >= 5) ? 16'h00FF : 16'h005A);
            chk("R8 hi unaffected", {8'h00, hi_w}, 16'h003C);
        end
        lo_oe_n = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            tick(1);
            chk("R9 lo on timing", {8'h00, lo_w}, (k >= 4) ? 16'h005A : 16'h00FF);
        end

        finish_run();
    end
endmodule